// File: doc/BRIEF.md
# Host Register Port with Pointer Addressing

This block connects an 8-bit host bus to a small bank of control registers. The host bus uses active-low strobes that are not tied to the block's clock. A write is brought into the system clock through a two-flop synchroniser. It takes effect on the rising edge of the write strobe. A read is combinational: while chip select and read strobe are both low, the block drives the shared data bus, and it releases the bus at all other times.

A strap input picks the addressing scheme. With the strap high, the 4-bit address bus names the target register directly. With it low, the host sees two locations only. Location 0 is a 4-bit pointer, and location 1 is a window onto the register that the pointer names. The bank holds a mode register with two filter enable bits and two 10-bit vertical position parameters: a back porch and an active end line. A second strap picks the reset values of the position parameters. A third strap makes the filter enable outputs follow two dedicated pins instead of the mode register.

The host must hold address, data and chip select stable from the falling edge of the write strobe until at least three clock cycles after its rising edge.

Top module: `hreg_port`

## Requirements
- R1: Reset is synchronous and active high. It clears the mode register to 0 (both filter enables off) and clears the pointer to 0.
- R2: At reset, with the centring strap high, the back porch loads 45 and the active end loads 530. With the strap low, they load 35 and 514.
- R3: While chip select is high, the data bus is not driven and a write strobe changes no register.
- R4: The data bus is driven only while chip select and read strobe are both low.
- R5: With the addressing strap high, the address bus selects a register directly. Location 2 is the mode register: bit 0 is the vertical filter enable and bit 1 is the horizontal filter enable. Location 4 is the back porch bits 7:0 and location 5 is its bits 9:8 in data bits 1:0. Location 6 is the active end bits 7:0 and location 7 is its bits 9:8 in data bits 1:0.
- R6: With the addressing strap low, location 0 reads and writes the pointer in data bits 3:0, and location 1 reads and writes the register that the pointer names, using the R5 numbering. All other locations read zero, and writes to them are ignored.
- R7: A write takes effect only after the write strobe rises. It is visible within four clock cycles of that rise, and no register changes while the strobe stays low.
- R8: Unimplemented register locations (0, 1, 3 and 8 to 15, reached directly or through the window) read zero, and writes to them change nothing. Unused high bits read zero.
- R9: With the filter-source strap high, the two filter enable outputs follow the filter pins. With it low, they follow mode register bits 0 and 1.
- R10: The back porch and active end outputs always show the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_addr | input | 4 | Register address |
| host_db | inout | 8 | Bidirectional data bus |
| addr_direct | input | 1 | 1: direct addressing, 0: pointer plus window |
| vpos_center | input | 1 | Selects the reset values of the vertical parameters |
| filt_from_pins | input | 1 | 1: filter enables come from pins, 0: from mode register |
| pin_vfilt | input | 1 | Vertical filter enable pin |
| pin_hfilt | input | 1 | Horizontal filter enable pin |
| vfilt_en | output | 1 | Vertical filter enable |
| hfilt_en | output | 1 | Horizontal filter enable |
| vbp | output | 10 | Vertical back porch parameter |
| vae | output | 10 | Vertical active end parameter |

## Verification
A corrupted pointer shows on the very next read of location 0 in pointer mode, and it sends the next window access to the wrong register. A broken synchroniser or edge detector shows as a register that changes while the strobe is still low, or that has not changed four cycles after the strobe rises. A bad field decode shows as a wrong bit or byte on the vbp, vae or filter outputs as soon as the write commits. Each of these shows again on read-back in the other addressing mode.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int HR_AW   = 4;
    localparam int HR_DW   = 8;
    localparam int HR_PW   = 10;
    localparam int HR_MW   = 2;
    localparam int HR_HIW  = HR_PW - HR_DW;

    localparam logic [HR_AW-1:0] LOC_PTR   = 4'd0;
    localparam logic [HR_AW-1:0] LOC_WIN   = 4'd1;
    localparam logic [HR_AW-1:0] IDX_MODE  = 4'd2;
    localparam logic [HR_AW-1:0] IDX_BP_LO = 4'd4;
    localparam logic [HR_AW-1:0] IDX_BP_HI = 4'd5;
    localparam logic [HR_AW-1:0] IDX_AE_LO = 4'd6;
    localparam logic [HR_AW-1:0] IDX_AE_HI = 4'd7;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_REG  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e             kind;
        logic [HR_AW-1:0] idx;
    } acc_s;

    typedef struct packed {
        logic [HR_MW-1:0] mode;
        logic [HR_PW-1:0] bp;
        logic [HR_PW-1:0] ae;
    } bank_s;

    function automatic logic is_impl(input logic [HR_AW-1:0] idx);
        return (idx == IDX_MODE) || (idx == IDX_BP_LO) || (idx == IDX_BP_HI) ||
               (idx == IDX_AE_LO) || (idx == IDX_AE_HI);
    endfunction

    function automatic logic [HR_PW-1:0] dflt_bp(input logic center);
        return center ? HR_PW'(45) : HR_PW'(35);
    endfunction

    function automatic logic [HR_PW-1:0] dflt_ae(input logic center);
        return center ? HR_PW'(530) : HR_PW'(514);
    endfunction

endpackage

// File: rtl/hreg_wr_sync.sv
module hreg_wr_sync
    import hreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [HR_AW-1:0] addr,
    input  logic [HR_DW-1:0] data,
    input  logic             direct,
    output logic             commit,
    output logic [HR_AW-1:0] cap_addr,
    output logic [HR_DW-1:0] cap_data,
    output logic             cap_direct
);

    logic [STAGES-1:0] wr_sync;
    logic              wr_prev;
    logic              cap_sel;
    logic              wr_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) wr_sync <= 1'b1;
                else     wr_sync <= wr_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) wr_sync <= '1;
                else     wr_sync <= {wr_sync[STAGES-2:0], wr_n};
            end
        end
    endgenerate

    assign wr_s = wr_sync[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev    <= 1'b1;
            cap_sel    <= 1'b0;
            cap_addr   <= '0;
            cap_data   <= '0;
            cap_direct <= 1'b0;
        end else begin
            wr_prev <= wr_s;
            if (!wr_s) begin
                cap_sel <= !cs_n;
                if (!cs_n) begin
                    cap_addr   <= addr;
                    cap_data   <= data;
                    cap_direct <= direct;
                end
            end else if (commit) begin
                cap_sel <= 1'b0;
            end
        end
    end

    assign commit = wr_s && !wr_prev && cap_sel;

    p_commit_once_r7: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

endmodule

// File: rtl/hreg_addr_dec.sv
module hreg_addr_dec
    import hreg_pkg::*;
(
    input  logic             direct,
    input  logic [HR_AW-1:0] bus_addr,
    input  logic [HR_AW-1:0] ptr,
    output acc_s             acc
);

    always_comb begin
        acc.kind = TGT_NONE;
        acc.idx  = bus_addr;
        if (direct) begin
            if (is_impl(bus_addr)) acc.kind = TGT_REG;
        end else if (bus_addr == LOC_PTR) begin
            acc.kind = TGT_PTR;
        end else if (bus_addr == LOC_WIN) begin
            acc.idx = ptr;
            if (is_impl(ptr)) acc.kind = TGT_REG;
        end
    end

endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
    import hreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             center,
    input  logic             wr_en,
    input  acc_s             wr_acc,
    input  logic [HR_DW-1:0] wr_data,
    input  logic [HR_AW-1:0] rd_idx,
    output logic [HR_DW-1:0] rd_val,
    output logic [HR_AW-1:0] ptr_q,
    output bank_s            regs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            regs_q.mode <= '0;
            regs_q.bp   <= dflt_bp(center);
            regs_q.ae   <= dflt_ae(center);
        end else if (wr_en) begin
            if (wr_acc.kind == TGT_PTR) begin
                ptr_q <= wr_data[HR_AW-1:0];
            end else if (wr_acc.kind == TGT_REG) begin
                case (wr_acc.idx)
                    IDX_MODE:  regs_q.mode               <= wr_data[HR_MW-1:0];
                    IDX_BP_LO: regs_q.bp[HR_DW-1:0]      <= wr_data;
                    IDX_BP_HI: regs_q.bp[HR_PW-1:HR_DW]  <= wr_data[HR_HIW-1:0];
                    IDX_AE_LO: regs_q.ae[HR_DW-1:0]      <= wr_data;
                    IDX_AE_HI: regs_q.ae[HR_PW-1:HR_DW]  <= wr_data[HR_HIW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_MODE:  rd_val = HR_DW'(regs_q.mode);
            IDX_BP_LO: rd_val = regs_q.bp[HR_DW-1:0];
            IDX_BP_HI: rd_val = HR_DW'(regs_q.bp[HR_PW-1:HR_DW]);
            IDX_AE_LO: rd_val = regs_q.ae[HR_DW-1:0];
            IDX_AE_HI: rd_val = HR_DW'(regs_q.ae[HR_PW-1:HR_DW]);
            default:   rd_val = '0;
        endcase
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({ptr_q, regs_q}));

    p_ptr_src_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr_q) |-> $past(wr_en && (wr_acc.kind == TGT_PTR)));

endmodule

// File: rtl/hreg_port.sv
module hreg_port
    import hreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_cs_n,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic [HR_AW-1:0] host_addr,
    inout  wire  [HR_DW-1:0] host_db,
    input  logic             addr_direct,
    input  logic             vpos_center,
    input  logic             filt_from_pins,
    input  logic             pin_vfilt,
    input  logic             pin_hfilt,
    output logic             vfilt_en,
    output logic             hfilt_en,
    output logic [HR_PW-1:0] vbp,
    output logic [HR_PW-1:0] vae
);

    logic             commit;
    logic [HR_AW-1:0] cap_addr;
    logic [HR_DW-1:0] cap_data;
    logic             cap_direct;
    logic [HR_AW-1:0] ptr_q;
    bank_s            regs_q;
    acc_s             wr_acc;
    acc_s             rd_acc;
    logic [HR_DW-1:0] rd_val;
    logic [HR_DW-1:0] rd_mux;
    logic             drive;

    hreg_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (host_cs_n),
        .wr_n       (host_wr_n),
        .addr       (host_addr),
        .data       (host_db),
        .direct     (addr_direct),
        .commit     (commit),
        .cap_addr   (cap_addr),
        .cap_data   (cap_data),
        .cap_direct (cap_direct)
    );

    hreg_addr_dec u_wdec (
        .direct   (cap_direct),
        .bus_addr (cap_addr),
        .ptr      (ptr_q),
        .acc      (wr_acc)
    );

    hreg_addr_dec u_rdec (
        .direct   (addr_direct),
        .bus_addr (host_addr),
        .ptr      (ptr_q),
        .acc      (rd_acc)
    );

    hreg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .center  (vpos_center),
        .wr_en   (commit),
        .wr_acc  (wr_acc),
        .wr_data (cap_data),
        .rd_idx  (rd_acc.idx),
        .rd_val  (rd_val),
        .ptr_q   (ptr_q),
        .regs_q  (regs_q)
    );

    always_comb begin
        case (rd_acc.kind)
            TGT_PTR: rd_mux = HR_DW'(ptr_q);
            TGT_REG: rd_mux = rd_val;
            default: rd_mux = '0;
        endcase
    end

    assign drive   = !host_cs_n && !host_rd_n;
    assign host_db = drive ? rd_mux : {HR_DW{1'bz}};

    assign vfilt_en = filt_from_pins ? pin_vfilt : regs_q.mode[0];
    assign hfilt_en = filt_from_pins ? pin_hfilt : regs_q.mode[1];
    assign vbp      = regs_q.bp;
    assign vae      = regs_q.ae;

    p_filt_pin_r9: assert property (@(posedge clk) disable iff (rst)
        filt_from_pins |-> (vfilt_en == pin_vfilt) && (hfilt_en == pin_hfilt));

endmodule

// File: tb/tb_hreg_port.sv
module tb_hreg_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic       direct = 1'b1, center = 1'b1, fsrc = 1'b0, pv = 1'b0, ph = 1'b0;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_dq = '0;
    wire  [7:0] db;
    logic       vf, hf;
    logic [9:0] vbp, vae;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] rv;

    assign db = tb_oe ? tb_dq : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    hreg_port dut (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_addr(addr), .host_db(db), .addr_direct(direct), .vpos_center(center),
        .filt_from_pins(fsrc), .pin_vfilt(pv), .pin_hfilt(ph),
        .vfilt_en(vf), .hfilt_en(hf), .vbp(vbp), .vae(vae)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic c);
        @(negedge clk);
        center = c; rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs_n = !sel; addr = a; tb_dq = d; tb_oe = 1'b1; wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        idle(4);
        cs_n = 1'b1; tb_oe = 1'b0;
        idle(1);
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2;
        d = db;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        chk("R1 vfilt after reset", vf, 0);
        chk("R1 hfilt after reset", hf, 0);
        chk("R2 bp centred", vbp, 45);
        chk("R2 ae centred", vae, 530);
        direct = 1'b0;
        hread(4'd0, rv);
        chk("R1 pointer after reset", rv, 0);
        direct = 1'b1;
        do_reset(1'b0);
        chk("R2 bp low strap", vbp, 35);
        chk("R2 ae low strap", vae, 514);
    endtask

    task automatic t_direct;
        direct = 1'b1;
        hwrite(4'd4, 8'h5A, 1'b1);
        hwrite(4'd5, 8'hFD, 1'b1);
        chk("R5 R10 bp value", vbp, 10'h15A);
        hwrite(4'd6, 8'hC3, 1'b1);
        hwrite(4'd7, 8'h02, 1'b1);
        chk("R5 R10 ae value", vae, 10'h2C3);
        hread(4'd4, rv); chk("R5 read bp lo", rv, 8'h5A);
        hread(4'd5, rv); chk("R5 R8 read bp hi", rv, 8'h01);
        hread(4'd7, rv); chk("R5 read ae hi", rv, 8'h02);
    endtask

    task automatic t_cs_and_bus;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 4'd4;
        #2;
        n_chk++;
        if (!((db === 8'hzz) || (db === 8'h00))) begin
            n_bad++;
            $display("FAIL R3 R4 bus driven with cs high actual=%0h expected=zz", db);
        end
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b0;
        #2;
        n_chk++;
        if (!((db === 8'hzz) || (db === 8'h00))) begin
            n_bad++;
            $display("FAIL R4 bus driven without read actual=%0h expected=zz", db);
        end
        @(negedge clk);
        cs_n = 1'b1;
        hwrite(4'd4, 8'h11, 1'b0);
        chk("R3 write ignored with cs high", vbp, 10'h15A);
    endtask

    task automatic t_indirect;
        direct = 1'b0;
        hwrite(4'd0, 8'hF6, 1'b1);
        hread(4'd0, rv); chk("R6 pointer readback", rv, 8'h06);
        hwrite(4'd1, 8'h77, 1'b1);
        chk("R6 window write ae lo", vae, 10'h277);
        hread(4'd1, rv); chk("R6 window read", rv, 8'h77);
        hwrite(4'd5, 8'h99, 1'b1);
        hread(4'd5, rv); chk("R6 other location reads zero", rv, 8'h00);
        chk("R6 other location write ignored bp", vbp, 10'h15A);
        chk("R6 other location write ignored ae", vae, 10'h277);
        hread(4'd0, rv); chk("R6 pointer unchanged", rv, 8'h06);
        hwrite(4'd0, 8'h03, 1'b1);
        hwrite(4'd1, 8'hFF, 1'b1);
        hread(4'd1, rv); chk("R8 window unimplemented reads zero", rv, 8'h00);
        direct = 1'b1;
        hread(4'd2, rv); chk("R8 mode untouched via window", rv, 8'h00);
    endtask

    task automatic t_unimpl;
        direct = 1'b1;
        hwrite(4'd3, 8'hFF, 1'b1);
        hwrite(4'd9, 8'hFF, 1'b1);
        hread(4'd3, rv); chk("R8 loc3 reads zero", rv, 0);
        hread(4'd9, rv); chk("R8 loc9 reads zero", rv, 0);
        hread(4'd0, rv); chk("R8 loc0 direct reads zero", rv, 0);
        chk("R8 bp unchanged", vbp, 10'h15A);
        chk("R8 ae unchanged", vae, 10'h277);
    endtask

    task automatic t_timing;
        direct = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; addr = 4'd4; tb_dq = 8'h3C; tb_oe = 1'b1; wr_n = 1'b0;
        idle(8);
        chk("R7 no change while strobe low", vbp, 10'h15A);
        wr_n = 1'b1;
        idle(4);
        chk("R7 committed within four cycles", vbp, 10'h13C);
        cs_n = 1'b1; tb_oe = 1'b0;
        idle(1);
    endtask

    task automatic t_filter;
        direct = 1'b1; fsrc = 1'b0;
        hwrite(4'd2, 8'hFD, 1'b1);
        chk("R9 vfilt from reg", vf, 1);
        chk("R9 hfilt from reg", hf, 0);
        hread(4'd2, rv); chk("R5 R8 mode readback", rv, 8'h01);
        fsrc = 1'b1; pv = 1'b0; ph = 1'b1;
        #1;
        chk("R9 vfilt from pin", vf, 0);
        chk("R9 hfilt from pin", hf, 1);
        fsrc = 1'b0;
        #1;
        chk("R9 back to reg", {vf, hf}, 2'b10);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_direct();
                t_cs_and_bus();
                t_indirect();
                t_unimpl();
                t_timing();
                t_filter();
            end
            begin
                idle(150000);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule